// File: doc/BRIEF.md
# Display Control Bus Master

This block connects a host register port to a narrow byte-wide bus that reaches display-side slave devices, such as a video timing unit, colour lookup tables and a pixel mapper. Software first writes a mode word. The mode word selects the slave, the register inside that slave, how many bytes move per access, the byte order, the chip-select timing and an optional acknowledge handshake. Writing the data register then sends one to four bytes to the selected slave. Reading the data register while the bus is idle starts a fetch that fills the data register byte by byte.

Each byte runs through the same three-phase cycle. First comes a setup phase, in which slave and register select are driven but the strobe is not. Next comes a strobe phase, in which chip select is asserted. Last comes a hold phase, in which the strobe is released. The register select can advance after every byte. This lets a burst walk through consecutive slave registers. A status word shows whether the bus is busy and whether the last access timed out while waiting for an acknowledge.

Top module: `dpb_master`

## Requirements
- R1: After reset, busy_o, err_o and bus_cs_o are 0. The mode register, the data register and the status word all read 0.
- R2: The mode bits [1:0] give the bytes per access. Codes 1, 2 and 3 move that many bytes, and code 0 moves 4 bytes. Mode bit 2 (packing) forces 4 bytes whatever the code.
- R3: With mode bit 28 clear, bytes travel most significant first: [31:24], [23:16], [15:8], [7:0]. With bit 28 set, the order is reversed, starting at [7:0].
- R4: Each byte takes setup cycles (mode [27:23]) with chip select low, then max(width,1) strobe cycles (mode [17:13]), then hold cycles (mode [22:18]) with chip select low. With no acknowledge enabled, busy_o stays high for exactly n*(setup+max(width,1)+hold) cycles after the accepting edge. With zero setup and zero hold, the strobe stays asserted across bytes.
- R5: bus_slv_o carries mode [10:7] and bus_rsel_o carries mode [6:4]. When mode bit 3 is set, the register select steps by one, modulo 8, after every byte, and the stepped value remains in the mode register.
- R6: When mode bit 11 is set, the strobe phase lasts until ack_sync_i is high at a clock edge and the minimum strobe width has elapsed.
- R7: When mode bit 12 is set, ack_async_i passes through a two-stage synchroniser before it can end the strobe phase.
- R8: If 256 strobe cycles pass without an enabled acknowledge, the access is aborted: the remaining bytes are dropped, busy_o falls and err_o is set. err_o clears on the next accepted access.
- R9: A host read of the data register (address 1) while idle starts a read. During a read, bus_we_o is 0. The data register is cleared, and each returned byte is placed in the lane that a write would have sent from.
- R10: Slave code 15 is never driven. Data-register writes or reads with slave 15 selected start nothing and leave the data register unchanged.
- R11: Host writes to the mode or data register while busy_o is high are ignored.
- R12: The host register map is: address 0 mode, address 1 data, address 2 status with bit 0 = busy and bit 1 = error. host_rdata_o is combinational from host_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host register write strobe |
| host_rd_i | input | 1 | Host register read strobe |
| host_addr_i | input | 2 | Host register address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data |
| busy_o | output | 1 | Bus access in progress |
| err_o | output | 1 | Last access aborted by timeout |
| bus_slv_o | output | 4 | Slave address on the display bus |
| bus_rsel_o | output | 3 | Register select within the slave |
| bus_cs_o | output | 1 | Chip select strobe |
| bus_we_o | output | 1 | 1 for write bytes, 0 for read bytes |
| bus_wdata_o | output | 8 | Byte being written |
| bus_rdata_i | input | 8 | Byte returned by the slave |
| ack_sync_i | input | 1 | Acknowledge in the clock domain |
| ack_async_i | input | 1 | Acknowledge from another domain |

## Verification
An access is accepted on the clock edge where the host strobe is seen, and busy_o and any strobe without setup appear right after that edge. The bench therefore counts busy and strobe cycles on falling edges, starting from a snapshot taken before the strobe, and compares them with the cycle count that R4 gives from the mode fields. A synchronous acknowledge ends the strobe on the edge where it is sampled. An asynchronous acknowledge needs two extra edges, so the expected strobe lengths after an acknowledge raised in a known cycle differ by exactly two. Register and data readback is sampled only after busy_o has been low for a full cycle, so the last increment or read byte has already been written.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = WORD_W / BYTE_W;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned TICK_W = 5;
  localparam int unsigned RSEL_W = 3;
  localparam int unsigned SLV_W  = 4;
  localparam int unsigned HADDR_W = 2;

  localparam logic [SLV_W-1:0]   SLV_RESERVED = '1;
  localparam logic [HADDR_W-1:0] HA_MODE = 2'd0;
  localparam logic [HADDR_W-1:0] HA_DATA = 2'd1;
  localparam logic [HADDR_W-1:0] HA_STAT = 2'd2;

  // field order fixed by software-visible bit positions
  typedef struct packed {
    logic [2:0]        rsvd;
    logic              swap;
    logic [TICK_W-1:0] setup;
    logic [TICK_W-1:0] hold;
    logic [TICK_W-1:0] width;
    logic              ack_async_en;
    logic              ack_sync_en;
    logic [SLV_W-1:0]  slv;
    logic [RSEL_W-1:0] rsel;
    logic              inc;
    logic              pack;
    logic [1:0]        wcode;
  } mode_t;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  function automatic logic [LANE_W:0] byte_total(mode_t m);
    if (m.pack || m.wcode == '0) return (LANE_W+1)'(LANES);
    return (LANE_W+1)'(m.wcode);
  endfunction

  // lane LANES-1 holds the most significant byte
  function automatic logic [LANE_W-1:0] lane_of(logic [LANE_W-1:0] idx, logic swap);
    return swap ? idx : LANE_W'(LANES - 1) - idx;
  endfunction
endpackage

// File: rtl/dpb_ack_sync.sv
module dpb_ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-2:0], async_i};
  end

  assign sync_o = q[STAGES-1];
endmodule

// File: rtl/dpb_lanes.sv
module dpb_lanes
  import dpb_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [WORD_W-1:0] merged_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged_o[g*BYTE_W +: BYTE_W] =
      (lane_i == LANE_W'(g)) ? byte_i : word_i[g*BYTE_W +: BYTE_W];
  end

  assign byte_o = word_i[lane_i*BYTE_W +: BYTE_W];
endmodule

// File: rtl/dpb_seq.sv
module dpb_seq
  import dpb_pkg::*;
#(
  parameter int unsigned TIMEOUT = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TICK_W-1:0] setup_i,
  input  logic [TICK_W-1:0] width_i,
  input  logic [TICK_W-1:0] hold_i,
  input  logic [LANE_W:0]   nbytes_i,
  input  logic              ack_en_i,
  input  logic              ack_i,
  output phase_e            phase_o,
  output logic [LANE_W-1:0] idx_o,
  output logic              strobe_end_o,
  output logic              byte_end_o,
  output logic              timeout_o
);
  localparam int unsigned TO_W  = $clog2(TIMEOUT);
  localparam int unsigned CNT_W = (TO_W > TICK_W) ? TO_W : TICK_W;

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LANE_W-1:0] idx_q;
  logic [CNT_W:0]    cnt_nx;
  logic [TICK_W-1:0] wmin;
  logic setup_met, width_met, hold_met, ack_ok, last_byte;

  assign cnt_nx    = {1'b0, cnt_q} + 1'b1;
  assign wmin      = (width_i == '0) ? TICK_W'(1) : width_i;
  assign setup_met = cnt_nx >= (CNT_W+1)'(setup_i);
  assign width_met = cnt_nx >= (CNT_W+1)'(wmin);
  assign hold_met  = cnt_nx >= (CNT_W+1)'(hold_i);
  assign ack_ok    = !ack_en_i || ack_i;
  assign last_byte = ({1'b0, idx_q} + 1'b1) == nbytes_i;

  assign strobe_end_o = (phase_q == PH_STROBE) && width_met && ack_ok;
  assign timeout_o    = (phase_q == PH_STROBE) && !ack_ok && (cnt_q == CNT_W'(TIMEOUT - 1));
  assign byte_end_o   = ((phase_q == PH_HOLD) && hold_met) || (strobe_end_o && hold_i == '0);

  // zero setup goes straight to the strobe
  function automatic phase_e entry_phase(logic [TICK_W-1:0] s);
    return (s == '0) ? PH_STROBE : PH_SETUP;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      cnt_q <= cnt_nx[CNT_W-1:0];
      case (phase_q)
        PH_IDLE: begin
          cnt_q <= '0;
          if (start_i) begin
            idx_q   <= '0;
            phase_q <= entry_phase(setup_i);
          end
        end
        PH_SETUP: begin
          if (setup_met) begin
            phase_q <= PH_STROBE;
            cnt_q   <= '0;
          end
        end
        PH_STROBE: begin
          if (timeout_o) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else if (strobe_end_o) begin
            cnt_q <= '0;
            if (hold_i != '0) begin
              phase_q <= PH_HOLD;
            end else if (last_byte) begin
              phase_q <= PH_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              phase_q <= entry_phase(setup_i);
            end
          end
        end
        PH_HOLD: begin
          if (hold_met) begin
            cnt_q <= '0;
            if (last_byte) begin
              phase_q <= PH_IDLE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              phase_q <= entry_phase(setup_i);
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/dpb_master.sv
module dpb_master
  import dpb_pkg::*;
#(
  parameter int unsigned TIMEOUT     = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_wr_i,
  input  logic                host_rd_i,
  input  logic [HADDR_W-1:0]  host_addr_i,
  input  logic [WORD_W-1:0]   host_wdata_i,
  output logic [WORD_W-1:0]   host_rdata_o,
  output logic                busy_o,
  output logic                err_o,
  output logic [SLV_W-1:0]    bus_slv_o,
  output logic [RSEL_W-1:0]   bus_rsel_o,
  output logic                bus_cs_o,
  output logic                bus_we_o,
  output logic [BYTE_W-1:0]   bus_wdata_o,
  input  logic [BYTE_W-1:0]   bus_rdata_i,
  input  logic                ack_sync_i,
  input  logic                ack_async_i
);
  mode_t             mode_q;
  logic [WORD_W-1:0] data_q;
  logic              is_read_q;
  logic              err_q;

  phase_e            phase;
  logic [LANE_W-1:0] idx;
  logic [LANE_W-1:0] lane;
  logic [BYTE_W-1:0] cur_byte;
  logic [WORD_W-1:0] merged;
  logic strobe_end, byte_end, timeout;
  logic ack_async_s, ack_any, ack_en;
  logic idle, slv_ok, wr_mode, start_wr, start_rd, start;

  assign idle     = (phase == PH_IDLE);
  assign slv_ok   = (mode_q.slv != SLV_RESERVED);
  assign wr_mode  = host_wr_i && host_addr_i == HA_MODE && idle;
  assign start_wr = host_wr_i && host_addr_i == HA_DATA && idle && slv_ok;
  assign start_rd = !host_wr_i && host_rd_i && host_addr_i == HA_DATA && idle && slv_ok;
  assign start    = start_wr || start_rd;

  assign ack_en  = mode_q.ack_sync_en || mode_q.ack_async_en;
  assign ack_any = (mode_q.ack_sync_en && ack_sync_i) || (mode_q.ack_async_en && ack_async_s);
  assign lane    = lane_of(idx, mode_q.swap);

  dpb_ack_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ack_async_i),
    .sync_o  (ack_async_s)
  );

  dpb_seq #(.TIMEOUT(TIMEOUT)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .setup_i      (mode_q.setup),
    .width_i      (mode_q.width),
    .hold_i       (mode_q.hold),
    .nbytes_i     (byte_total(mode_q)),
    .ack_en_i     (ack_en),
    .ack_i        (ack_any),
    .phase_o      (phase),
    .idx_o        (idx),
    .strobe_end_o (strobe_end),
    .byte_end_o   (byte_end),
    .timeout_o    (timeout)
  );

  dpb_lanes u_lanes (
    .word_i   (data_q),
    .lane_i   (lane),
    .byte_i   (bus_rdata_i),
    .byte_o   (cur_byte),
    .merged_o (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (wr_mode) begin
      mode_q <= mode_t'(host_wdata_i);
    end else if (byte_end && mode_q.inc) begin
      mode_q.rsel <= mode_q.rsel + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q    <= '0;
      is_read_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (start) begin
        is_read_q <= start_rd;
        err_q     <= 1'b0;
      end else if (timeout) begin
        err_q <= 1'b1;
      end
      if (start_wr)                    data_q <= host_wdata_i;
      else if (start_rd)               data_q <= '0;
      else if (strobe_end && is_read_q) data_q <= merged;
    end
  end

  always_comb begin
    case (host_addr_i)
      HA_MODE: host_rdata_o = mode_q;
      HA_DATA: host_rdata_o = data_q;
      HA_STAT: host_rdata_o = {{(WORD_W-2){1'b0}}, err_q, !idle};
      default: host_rdata_o = '0;
    endcase
  end

  assign busy_o      = !idle;
  assign err_o       = err_q;
  assign bus_cs_o    = (phase == PH_STROBE);
  assign bus_slv_o   = idle ? '0 : mode_q.slv;
  assign bus_rsel_o  = mode_q.rsel;
  assign bus_we_o    = !idle && !is_read_q;
  assign bus_wdata_o = bus_we_o ? cur_byte : '0;
endmodule

// File: rtl/dpb_master_chk.sv
module dpb_master_chk
  import dpb_pkg::*;
#(
  parameter int unsigned TIMEOUT = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             err_o,
  input logic             bus_cs_o,
  input logic             bus_we_o,
  input logic [SLV_W-1:0] bus_slv_o
);
  localparam int unsigned RUN_W = $clog2(TIMEOUT + 2);
  logic [RUN_W-1:0] cs_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cs_run <= '0;
    else if (bus_cs_o) cs_run <= cs_run + 1'b1;
    else               cs_run <= '0;
  end

  a_r4_strobe_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cs_o |-> busy_o);

  a_r4_write_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> busy_o);

  a_r10_no_reserved_slave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> bus_slv_o != SLV_RESERVED);

  a_r8_err_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !err_o);

  a_r8_strobe_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_run <= RUN_W'(TIMEOUT));
endmodule

bind dpb_master dpb_master_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .err_o     (err_o),
  .bus_cs_o  (bus_cs_o),
  .bus_we_o  (bus_we_o),
  .bus_slv_o (bus_slv_o)
);

// File: tb/sim_dpb_master.sv
`timescale 1ns/1ps
module sim_dpb_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy, err, cs, we;
  logic [3:0]  slv;
  logic [2:0]  rsel;
  logic [7:0]  bwdata, brdata;
  logic        ack_s = 1'b0, ack_a = 1'b0;

  always #10 clk = ~clk;

  dpb_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_rd_i(rd), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .busy_o(busy), .err_o(err),
    .bus_slv_o(slv), .bus_rsel_o(rsel), .bus_cs_o(cs), .bus_we_o(we),
    .bus_wdata_o(bwdata), .bus_rdata_i(brdata), .ack_sync_i(ack_s), .ack_async_i(ack_a)
  );

  // slave model: returned byte depends on register select
  assign brdata = 8'h30 + {5'b0, rsel};

  int total = 0, bad = 0;
  int n_pulse = 0, n_busy = 0, n_cs = 0;
  logic cs_d = 1'b0;
  logic [7:0] log_b [64];
  logic [2:0] log_r [64];
  logic [3:0] log_s [64];
  logic       log_w [64];

  always @(negedge clk) begin
    if (busy) n_busy++;
    if (cs) n_cs++;
    if (cs && !cs_d) begin
      log_b[n_pulse % 64] = bwdata;
      log_r[n_pulse % 64] = rsel;
      log_s[n_pulse % 64] = slv;
      log_w[n_pulse % 64] = we;
      n_pulse++;
    end
    cs_d = cs;
  end

  function automatic logic [31:0] mk_mode(int wc, int pk, int inc, int rs, int sl, int sa,
                                          int aa, int w, int h, int s, int sw);
    logic [31:0] m;
    m = '0;
    m[1:0] = wc[1:0]; m[2] = pk[0]; m[3] = inc[0]; m[6:4] = rs[2:0]; m[10:7] = sl[3:0];
    m[11] = sa[0]; m[12] = aa[0]; m[17:13] = w[4:0]; m[22:18] = h[4:0];
    m[27:23] = s[4:0]; m[28] = sw[0];
    return m;
  endfunction

  localparam int NV = 7;
  localparam logic [31:0] VDATA = 32'hA1B2C3D4;
  localparam logic [31:0] V_MODE [NV] = '{
    mk_mode(1, 0, 0, 0, 3, 0, 0, 1, 0, 0, 0),
    mk_mode(2, 0, 1, 6, 0, 0, 0, 2, 1, 1, 0),
    mk_mode(3, 0, 0, 5, 2, 0, 0, 0, 2, 2, 0),
    mk_mode(0, 0, 0, 1, 4, 0, 0, 3, 1, 0, 0),
    mk_mode(1, 1, 0, 0, 5, 0, 0, 1, 0, 1, 0),
    mk_mode(2, 0, 0, 0, 6, 0, 0, 1, 1, 1, 1),
    mk_mode(0, 0, 1, 7, 7, 0, 0, 1, 1, 0, 1)
  };
  localparam logic [31:0] V_EXP [NV] = '{
    32'hA1000000, 32'hA1B20000, 32'hA1B2C300, 32'hA1B2C3D4,
    32'hA1B2C3D4, 32'hD4C30000, 32'hD4C3B2A1
  };
  localparam int V_N [NV] = '{1, 2, 3, 4, 4, 2, 4};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic host_read_trig();
    @(negedge clk); rd = 1'b1; addr = 2'd1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(posedge clk); #2;
  endtask

  bit done = 1'b0;

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int bp, bb, bc;
    // R1 / R12 reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 err", {31'b0, err}, 32'd0);
    chk("R1 cs", {31'b0, cs}, 32'd0);
    peek(2'd0, r); chk("R1 mode", r, 32'd0);
    peek(2'd1, r); chk("R1 data", r, 32'd0);
    peek(2'd2, r); chk("R12 status", r, 32'd0);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      logic [31:0] m;
      int s, w, h, cyc, rs0, ex_rs;
      m = V_MODE[v];
      s = int'(m[27:23]); w = int'(m[17:13]); h = int'(m[22:18]);
      if (w == 0) w = 1;
      cyc = V_N[v] * (s + w + h);
      host_write(2'd0, m);
      bp = n_pulse; bb = n_busy;
      host_write(2'd1, VDATA);
      wait_idle();
      chk($sformatf("R2 v%0d count", v), n_pulse - bp, V_N[v]);
      rs0 = int'(m[6:4]);
      for (int k = 0; k < V_N[v]; k++) begin
        ex_rs = (rs0 + (m[3] ? k : 0)) % 8;
        chk($sformatf("R3 v%0d byte%0d", v, k), {24'b0, log_b[(bp + k) % 64]}, {24'b0, V_EXP[v][31 - 8*k -: 8]});
        chk($sformatf("R5 v%0d rsel%0d", v, k), {29'b0, log_r[(bp + k) % 64]}, ex_rs);
        chk($sformatf("R5 v%0d slv%0d", v, k), {28'b0, log_s[(bp + k) % 64]}, {28'b0, m[10:7]});
        chk($sformatf("R4 v%0d we%0d", v, k), {31'b0, log_w[(bp + k) % 64]}, 32'd1);
      end
      chk($sformatf("R4 v%0d busy cycles", v), n_busy - bb, cyc);
      peek(2'd0, r);
      chk($sformatf("R5 v%0d final rsel", v), {29'b0, r[6:4]}, (rs0 + (m[3] ? V_N[v] : 0)) % 8);
    end

    // R10 reserved slave
    host_write(2'd0, mk_mode(1, 0, 0, 0, 15, 0, 0, 1, 0, 0, 0));
    bp = n_pulse; bb = n_busy;
    host_write(2'd1, 32'h11223344);
    repeat (4) @(negedge clk);
    chk("R10 no pulse", n_pulse - bp, 0);
    chk("R10 no busy", n_busy - bb, 0);
    peek(2'd1, r); chk("R10 data kept", r, VDATA);

    // R11 writes ignored while busy
    host_write(2'd0, mk_mode(0, 0, 0, 0, 3, 0, 0, 8, 1, 0, 0));
    bp = n_pulse;
    host_write(2'd1, 32'h01020304);
    host_write(2'd0, 32'h0);
    host_write(2'd1, 32'hFFFFFFFF);
    wait_idle();
    chk("R11 count", n_pulse - bp, 4);
    chk("R11 last byte", {24'b0, log_b[(bp + 3) % 64]}, 32'h04);
    peek(2'd0, r); chk("R11 mode kept", r, mk_mode(0, 0, 0, 0, 3, 0, 0, 8, 1, 0, 0));
    peek(2'd1, r); chk("R11 data kept", r, 32'h01020304);

    // R6 synchronous acknowledge: raised 4 cycles after the accept
    host_write(2'd0, mk_mode(1, 0, 0, 0, 2, 1, 0, 1, 0, 0, 0));
    bc = n_cs; bb = n_busy;
    host_write(2'd1, VDATA);
    repeat (4) @(negedge clk);
    ack_s = 1'b1;
    @(negedge clk); ack_s = 1'b0;
    wait_idle();
    chk("R6 strobe cycles", n_cs - bc, 5);
    chk("R6 busy cycles", n_busy - bb, 5);

    // R7 asynchronous acknowledge: two more cycles for the synchroniser
    host_write(2'd0, mk_mode(1, 0, 0, 0, 2, 0, 1, 1, 0, 0, 0));
    bc = n_cs;
    host_write(2'd1, VDATA);
    repeat (4) @(negedge clk);
    ack_a = 1'b1;
    repeat (4) @(negedge clk);
    ack_a = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R7 strobe cycles", n_cs - bc, 7);

    // R8 timeout
    host_write(2'd0, mk_mode(2, 0, 0, 0, 2, 1, 0, 1, 0, 0, 0));
    bc = n_cs; bp = n_pulse;
    host_write(2'd1, VDATA);
    wait_idle();
    chk("R8 strobe cycles", n_cs - bc, 256);
    chk("R8 bytes dropped", n_pulse - bp, 1);
    peek(2'd2, r); chk("R8 status err", r, 32'd2);
    host_write(2'd0, mk_mode(1, 0, 0, 0, 3, 0, 0, 4, 0, 0, 0));
    host_write(2'd1, VDATA);
    peek(2'd2, r); chk("R8 err cleared", r, 32'd1);
    wait_idle();

    // R9 read with auto-increment from register 2
    host_write(2'd0, mk_mode(3, 0, 1, 2, 1, 0, 0, 1, 1, 0, 0));
    bp = n_pulse; bb = n_busy;
    host_read_trig();
    wait_idle();
    peek(2'd1, r); chk("R9 read data", r, 32'h32333400);
    chk("R9 count", n_pulse - bp, 3);
    chk("R9 we low", {31'b0, log_w[bp % 64] | log_w[(bp + 1) % 64] | log_w[(bp + 2) % 64]}, 32'd0);
    chk("R9 busy cycles", n_busy - bb, 6);
    peek(2'd0, r); chk("R9 final rsel", {29'b0, r[6:4]}, 32'd5);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule